// File: doc/BRIEF.md
# Predicted Next Fetch Address Unit

This unit steers instruction fetch one group at a time. It holds the address of the current fetch group. In every cycle it looks up a direct-mapped branch target buffer and a table of two-bit saturating counters, both indexed from that address, in parallel. From the two results it produces the address of the next group, a mask of the slots in the current group that may go downstream, and a flag that says a taken branch was predicted. A group carries up to `SLOTS` instructions of 4 bytes each. The caller supplies the width of each group.

A predicted-taken branch does two things. It cuts the current group just after the branch slot, and it sends the next fetch to the stored target. Otherwise the next fetch is the sequential address after the group. Branch resolution writes through an update port. Each update rewrites one buffer entry (valid, partial tag, slot offset, target) and moves one counter a single step toward the resolved outcome. A redirect input from the back end overrides any prediction and loads a corrected address.

Control is a two-state machine:
- `ST_BOOT` is the single cycle after reset. No slot is valid and the address is held.
- `ST_FETCH` is normal operation.
- Transition `BOOT_DONE` (`ST_BOOT` to `ST_FETCH`) is taken unconditionally on the first clock after reset.
- Transition `FETCH_STAY` (`ST_FETCH` to `ST_FETCH`) is taken on every later clock.
- A redirect is accepted in either state.

Top module: `nfa_top`

## Requirements
- R1: While reset is applied and in the first cycle after it, `cur_pc` equals `RESET_PC` (default 0x1000), `slot_valid` is 0, `pred_taken` is 0 and `next_pc` equals `cur_pc`. Reset clears every buffer entry to invalid and sets every counter to 1 (weakly not taken).
- R2: The effective width W is `grp_width` limited to the range 1..SLOTS. A value of 0 is treated as 1, and a value above SLOTS is treated as SLOTS.
- R3: With no taken prediction and no redirect, in the fetch state `next_pc` = `cur_pc` + 4·W, bits 0..W-1 of `slot_valid` are set and all other bits are clear, and `pred_taken` is 0.
- R4: A buffer hit requires three conditions. The entry at index `cur_pc[5:2]` is valid. Its stored tag equals `cur_pc[13:6]`. Its stored slot is below W. A tag mismatch is a miss and follows R3, whatever the counter holds.
- R5: On a hit where the counter at index `cur_pc[7:2]` is 2 or 3, the outputs are as follows. `pred_taken` is 1. `next_pc` is the stored target. `slot_valid` has bits 0..slot set and all other bits clear.
- R6: On a hit where that counter is 0 or 1, the outputs follow R3.
- R7: With `upd_en` high at a clock edge, the update does two things. It writes the entry at index `upd_pc[5:2]` with valid=1, tag `upd_pc[13:6]`, slot `upd_slot` and target `upd_target`. It moves the counter at `upd_pc[7:2]` up by one if `upd_taken`, or down by one otherwise, saturating at 3 and 0.
- R8: An update counts from the cycle after its edge. A lookup in the same cycle as an update to the same entry sees the old contents.
- R9: In a cycle with `redirect` high, `slot_valid` is 0, `pred_taken` is 0 and `next_pc` equals `redir_pc`. In the following cycle `cur_pc` equals `redir_pc`.
- R10: Without a redirect, `cur_pc` in the following cycle equals the `next_pc` of the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_width | input | 3 | Requested number of instructions in the current group |
| redirect | input | 1 | Back-end correction; overrides prediction |
| redir_pc | input | 32 | Corrected fetch address |
| upd_en | input | 1 | Branch resolution update strobe |
| upd_pc | input | 32 | Fetch-group address of the resolved branch |
| upd_slot | input | 2 | Slot of the branch within its group |
| upd_target | input | 32 | Resolved target address |
| upd_taken | input | 1 | Resolved direction |
| cur_pc | output | 32 | Address of the current fetch group |
| next_pc | output | 32 | Predicted address of the next group |
| slot_valid | output | 4 | Slots of the current group passed downstream |
| pred_taken | output | 1 | A taken branch was predicted in this group |

## Verification
Two functions can fall in the same cycle.

The first pair is an update and a lookup of the same entry. The bench presents a group address while it drives a taken update for that address in the same cycle. It expects the fall-through result in that cycle. After the cycle it moves back to the address with a redirect and expects the taken result.

The second pair is a redirect and a taken prediction. The bench redirects while the current group hits a trained taken branch. It expects an empty mask, no taken flag and the redirect address, and it expects that address to become the group address on the next cycle.

Both cases are judged against a table model that the bench keeps, with results computed arithmetically.

// File: rtl/nfa_pkg.sv
package nfa_pkg;

    typedef enum logic [0:0] {
        ST_BOOT  = 1'b0,
        ST_FETCH = 1'b1
    } nfa_state_e;

    localparam int unsigned INSTR_BYTES = 4;

    localparam logic [1:0] CTR_WEAK_NT = 2'd1;
    localparam logic [1:0] CTR_MAX     = 2'd3;
    localparam logic [1:0] CTR_MIN     = 2'd0;

endpackage

// File: rtl/nfa_btb.sv
module nfa_btb #(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned TAG_W  = 8,
    parameter int unsigned SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   rd_pc,
    output logic              rd_match,
    output logic [SLOT_W-1:0] rd_slot,
    output logic [XLEN-1:0]   rd_target,
    input  logic              wr_en,
    input  logic [XLEN-1:0]   wr_pc,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [XLEN-1:0]   wr_target
);
    localparam int unsigned IDX_W  = $clog2(DEPTH);
    localparam int unsigned IDX_LO = 2;
    localparam int unsigned TAG_LO = IDX_LO + IDX_W;

    logic [DEPTH-1:0]  ent_vld;
    logic [TAG_W-1:0]  ent_tag [DEPTH];
    logic [SLOT_W-1:0] ent_slot[DEPTH];
    logic [XLEN-1:0]   ent_tgt [DEPTH];

    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    logic [TAG_W-1:0] rd_tag;
    logic [TAG_W-1:0] wr_tag;

    assign rd_idx = rd_pc[IDX_LO +: IDX_W];
    assign wr_idx = wr_pc[IDX_LO +: IDX_W];
    assign rd_tag = rd_pc[TAG_LO +: TAG_W];
    assign wr_tag = wr_pc[TAG_LO +: TAG_W];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_vld[e] <= 1'b0;
            end else if (sel) begin
                ent_vld[e] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_tag[e]  <= '0;
                ent_slot[e] <= '0;
                ent_tgt[e]  <= '0;
            end else if (sel) begin
                ent_tag[e]  <= wr_tag;
                ent_slot[e] <= wr_slot;
                ent_tgt[e]  <= wr_target;
            end
        end
    end

    always_comb begin
        rd_match  = ent_vld[rd_idx] && (ent_tag[rd_idx] == rd_tag);
        rd_slot   = ent_slot[rd_idx];
        rd_target = ent_tgt[rd_idx];
    end

endmodule

// File: rtl/nfa_pht.sv
module nfa_pht
    import nfa_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned DEPTH = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] rd_pc,
    output logic [1:0]      rd_ctr,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_pc,
    input  logic            wr_taken
);
    localparam int unsigned IDX_W  = $clog2(DEPTH);
    localparam int unsigned IDX_LO = 2;

    logic [1:0]       ctr [DEPTH];
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;

    assign rd_idx = rd_pc[IDX_LO +: IDX_W];
    assign wr_idx = wr_pc[IDX_LO +: IDX_W];

    for (genvar c = 0; c < DEPTH; c++) begin : g_ctr
        logic       sel;
        logic [1:0] stepped;

        assign sel = wr_en && (wr_idx == IDX_W'(c));

        always_comb begin
            stepped = ctr[c];
            if (wr_taken) begin
                if (ctr[c] != CTR_MAX) stepped = ctr[c] + 2'd1;
            end else begin
                if (ctr[c] != CTR_MIN) stepped = ctr[c] - 2'd1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctr[c] <= CTR_WEAK_NT;
            end else if (sel) begin
                ctr[c] <= stepped;
            end
        end
    end

    assign rd_ctr = ctr[rd_idx];

endmodule

// File: rtl/nfa_slot_mask.sv
module nfa_slot_mask #(
    parameter int unsigned SLOTS = 4,
    parameter int unsigned CNT_W = $clog2(SLOTS + 1)
) (
    input  logic [CNT_W-1:0] count,
    output logic [SLOTS-1:0] mask
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_bit
        assign mask[s] = (CNT_W'(s) < count);
    end

endmodule

// File: rtl/nfa_top.sv
module nfa_top
    import nfa_pkg::*;
#(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned SLOTS     = 4,
    parameter int unsigned BTB_DEPTH = 16,
    parameter int unsigned PHT_DEPTH = 64,
    parameter int unsigned TAG_W     = 8,
    parameter logic [31:0] RESET_PC  = 32'h0000_1000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(SLOTS+1)-1:0]   grp_width,
    input  logic                         redirect,
    input  logic [XLEN-1:0]              redir_pc,
    input  logic                         upd_en,
    input  logic [XLEN-1:0]              upd_pc,
    input  logic [$clog2(SLOTS)-1:0]     upd_slot,
    input  logic [XLEN-1:0]              upd_target,
    input  logic                         upd_taken,
    output logic [XLEN-1:0]              cur_pc,
    output logic [XLEN-1:0]              next_pc,
    output logic [SLOTS-1:0]             slot_valid,
    output logic                         pred_taken
);
    localparam int unsigned WID_W  = $clog2(SLOTS + 1);
    localparam int unsigned SLOT_W = $clog2(SLOTS);

    nfa_state_e state_q;
    nfa_state_e state_d;
    logic [XLEN-1:0] pc_q;
    logic            fetching;

    logic [WID_W-1:0] w_eff;
    logic [WID_W-1:0] cut_cnt;
    logic [SLOTS-1:0] seq_mask;
    logic [SLOTS-1:0] cut_mask;
    logic [XLEN-1:0]  seq_pc;

    logic              btb_match;
    logic [SLOT_W-1:0] btb_slot;
    logic [XLEN-1:0]   btb_target;
    logic [1:0]        pht_ctr;
    logic              hit;
    logic              taken;

    // width limited to 1..SLOTS
    always_comb begin
        if (grp_width == '0) begin
            w_eff = WID_W'(1);
        end else if (grp_width > WID_W'(SLOTS)) begin
            w_eff = WID_W'(SLOTS);
        end else begin
            w_eff = grp_width;
        end
    end

    nfa_btb #(
        .XLEN   (XLEN),
        .DEPTH  (BTB_DEPTH),
        .TAG_W  (TAG_W),
        .SLOT_W (SLOT_W)
    ) btb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_pc     (pc_q),
        .rd_match  (btb_match),
        .rd_slot   (btb_slot),
        .rd_target (btb_target),
        .wr_en     (upd_en),
        .wr_pc     (upd_pc),
        .wr_slot   (upd_slot),
        .wr_target (upd_target)
    );

    nfa_pht #(
        .XLEN  (XLEN),
        .DEPTH (PHT_DEPTH)
    ) pht_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_pc    (pc_q),
        .rd_ctr   (pht_ctr),
        .wr_en    (upd_en),
        .wr_pc    (upd_pc),
        .wr_taken (upd_taken)
    );

    assign cut_cnt = WID_W'(btb_slot) + WID_W'(1);

    nfa_slot_mask #(.SLOTS(SLOTS), .CNT_W(WID_W)) seq_mask_i (
        .count (w_eff),
        .mask  (seq_mask)
    );

    nfa_slot_mask #(.SLOTS(SLOTS), .CNT_W(WID_W)) cut_mask_i (
        .count (cut_cnt),
        .mask  (cut_mask)
    );

    assign seq_pc = pc_q + (XLEN'(w_eff) * XLEN'(INSTR_BYTES));
    assign hit    = btb_match && (WID_W'(btb_slot) < w_eff);
    assign taken  = hit && pht_ctr[1];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  state_d = ST_FETCH;
            ST_FETCH: state_d = ST_FETCH;
            default:  state_d = ST_BOOT;
        endcase
    end

    // outputs
    always_comb begin
        next_pc    = pc_q;
        slot_valid = '0;
        pred_taken = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                next_pc    = pc_q;
                slot_valid = '0;
                pred_taken = 1'b0;
            end
            ST_FETCH: begin
                if (taken) begin
                    next_pc    = btb_target;
                    slot_valid = cut_mask;
                    pred_taken = 1'b1;
                end else begin
                    next_pc    = seq_pc;
                    slot_valid = seq_mask;
                    pred_taken = 1'b0;
                end
            end
            default: begin
                next_pc    = pc_q;
                slot_valid = '0;
                pred_taken = 1'b0;
            end
        endcase
        if (redirect) begin
            next_pc    = redir_pc;
            slot_valid = '0;
            pred_taken = 1'b0;
        end
    end

    // group address register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= XLEN'(RESET_PC);
        end else begin
            pc_q <= next_pc;
        end
    end

    assign cur_pc   = pc_q;
    assign fetching = (state_q == ST_FETCH);

endmodule

// File: rtl/nfa_top_chk.sv
module nfa_top_chk #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned SLOTS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             redirect,
    input logic [XLEN-1:0]  redir_pc,
    input logic [XLEN-1:0]  cur_pc,
    input logic [XLEN-1:0]  next_pc,
    input logic [SLOTS-1:0] slot_valid,
    input logic             pred_taken,
    input logic             fetching
);

    AST_BOOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fetching |-> (slot_valid == '0 && !pred_taken)); // R1

    AST_MASK_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid & (slot_valid + SLOTS'(1))) == '0); // R3

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fetching && !redirect && !pred_taken) |->
        ((next_pc - cur_pc) == XLEN'(4 * $countones(slot_valid)))); // R3

    AST_TAKEN_HAS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> (slot_valid != '0)); // R5

    AST_REDIRECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (slot_valid == '0 && !pred_taken && next_pc == redir_pc)); // R9

    AST_REDIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (cur_pc == $past(redir_pc))); // R9

    AST_NEXT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect |=> (cur_pc == $past(next_pc))); // R10

endmodule

bind nfa_top nfa_top_chk #(
    .XLEN  (XLEN),
    .SLOTS (SLOTS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .redirect   (redirect),
    .redir_pc   (redir_pc),
    .cur_pc     (cur_pc),
    .next_pc    (next_pc),
    .slot_valid (slot_valid),
    .pred_taken (pred_taken),
    .fetching   (fetching)
);

// File: tb/nfa_top_tb_top.sv
`timescale 1ns/1ps
module nfa_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  grp_width = 3'd4;
    logic        redirect = 1'b0;
    logic [31:0] redir_pc = '0;
    logic        upd_en = 1'b0;
    logic [31:0] upd_pc = '0;
    logic [1:0]  upd_slot = '0;
    logic [31:0] upd_target = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] cur_pc;
    logic [31:0] next_pc;
    logic [3:0]  slot_valid;
    logic        pred_taken;

    int nchk = 0;
    int nbad = 0;

    // bench table model
    logic        m_vld [16];
    logic [7:0]  m_tag [16];
    logic [1:0]  m_slot[16];
    logic [31:0] m_tgt [16];
    logic [1:0]  m_ctr [64];

    always #5 clk = ~clk;

    nfa_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .grp_width  (grp_width),
        .redirect   (redirect),
        .redir_pc   (redir_pc),
        .upd_en     (upd_en),
        .upd_pc     (upd_pc),
        .upd_slot   (upd_slot),
        .upd_target (upd_target),
        .upd_taken  (upd_taken),
        .cur_pc     (cur_pc),
        .next_pc    (next_pc),
        .slot_valid (slot_valid),
        .pred_taken (pred_taken)
    );

    // R7 model: write takes effect at the edge
    always @(posedge clk) begin
        if (rst_n && upd_en) begin
            m_vld[upd_pc[5:2]]  <= 1'b1;
            m_tag[upd_pc[5:2]]  <= upd_pc[13:6];
            m_slot[upd_pc[5:2]] <= upd_slot;
            m_tgt[upd_pc[5:2]]  <= upd_target;
            if (upd_taken && m_ctr[upd_pc[7:2]] != 2'd3)
                m_ctr[upd_pc[7:2]] <= m_ctr[upd_pc[7:2]] + 2'd1;
            else if (!upd_taken && m_ctr[upd_pc[7:2]] != 2'd0)
                m_ctr[upd_pc[7:2]] <= m_ctr[upd_pc[7:2]] - 2'd1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic void predict(input logic [31:0] pc, input logic [2:0] w,
                                    output logic [31:0] nx, output logic [3:0] m,
                                    output logic tk);
        int we;
        int bi;
        int sl;
        logic hit;
        we  = (w == 0) ? 1 : (w > 4) ? 4 : int'(w);
        bi  = int'(pc[5:2]);
        sl  = int'(m_slot[bi]);
        hit = m_vld[bi] && (m_tag[bi] == pc[13:6]) && (sl < we);
        tk  = hit && (m_ctr[pc[7:2]] >= 2'd2);
        if (tk) begin
            nx = m_tgt[bi];
            m  = 4'((1 << (sl + 1)) - 1);
        end else begin
            nx = pc + 32'(4 * we);
            m  = 4'((1 << we) - 1);
        end
    endfunction

    task automatic check_model(input string req);
        logic [31:0] nx;
        logic [3:0]  m;
        logic        tk;
        predict(cur_pc, grp_width, nx, m, tk);
        chk({req, " next_pc"}, next_pc, nx);
        chk({req, " slot_valid"}, 32'(slot_valid), 32'(m));
        chk({req, " pred_taken"}, 32'(pred_taken), 32'(tk));
    endtask

    // load an address with a redirect, then look it up at width w
    task automatic look(input logic [31:0] pc, input logic [2:0] w, input string req);
        @(negedge clk);
        redirect = 1'b1;
        redir_pc = pc;
        #1;
        chk("R9 redirect mask", 32'(slot_valid), 32'd0);
        chk("R9 redirect next_pc", next_pc, pc);
        @(negedge clk);
        redirect  = 1'b0;
        grp_width = w;
        #1;
        chk("R9 loaded cur_pc", cur_pc, pc);
        check_model(req);
    endtask

    task automatic update(input logic [31:0] pc, input logic [1:0] s,
                          input logic [31:0] tgt, input logic tk);
        @(negedge clk);
        upd_en     = 1'b1;
        upd_pc     = pc;
        upd_slot   = s;
        upd_target = tgt;
        upd_taken  = tk;
        @(negedge clk);
        upd_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        nbad++;
        $display("FAIL watchdog act=%0d exp=%0d", nchk, 0);
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        logic [31:0] prev_next;
        logic [31:0] miss_pcs [3];
        for (int i = 0; i < 16; i++) begin
            m_vld[i] = 1'b0; m_tag[i] = '0; m_slot[i] = '0; m_tgt[i] = '0;
        end
        for (int i = 0; i < 64; i++) m_ctr[i] = 2'd1;

        // R1 reset and boot cycle
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset cur_pc", cur_pc, 32'h1000);
        chk("R1 reset mask", 32'(slot_valid), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 boot cur_pc", cur_pc, 32'h1000);
        chk("R1 boot mask", 32'(slot_valid), 32'd0);
        chk("R1 boot taken", 32'(pred_taken), 32'd0);
        chk("R1 boot next_pc", next_pc, 32'h1000);
        @(negedge clk);
        #1;
        chk("R10 first fetch cur_pc", cur_pc, 32'h1000);
        chk("R3 first fetch next_pc", next_pc, 32'h1010);
        chk("R3 first fetch mask", 32'(slot_valid), 32'hF);

        // R2 R3 miss sweep over all widths
        miss_pcs[0] = 32'h0000_1000;
        miss_pcs[1] = 32'h0000_2344;
        miss_pcs[2] = 32'hFFFF_FFF8;
        for (int p = 0; p < 3; p++)
            for (int w = 0; w < 8; w++)
                look(miss_pcs[p], 3'(w), "R2 R3 miss");

        // R4 R5 R7: train one taken branch per slot, sweep widths
        for (int s = 0; s < 4; s++) begin
            update(32'h4000 + 32'(s * 8), 2'(s), 32'h9000 + 32'(s * 256), 1'b1);
            for (int w = 0; w < 8; w++)
                look(32'h4000 + 32'(s * 8), 3'(w), "R4 R5 trained");
        end

        // R6 R7 counter walk with saturation at both ends
        for (int k = 0; k < 3; k++) begin
            update(32'h4000, 2'd0, 32'h9000, 1'b0);
            look(32'h4000, 3'd4, "R6 R7 walk down");
        end
        for (int k = 0; k < 4; k++) begin
            update(32'h4000, 2'd0, 32'h9000, 1'b1);
            look(32'h4000, 3'd4, "R5 R7 walk up");
        end
        update(32'h4000, 2'd0, 32'h9000, 1'b0);
        look(32'h4000, 3'd4, "R5 R7 strong then one not-taken");
        chk("R7 counter 2 still taken", 32'(pred_taken), 32'd1);

        // R4 tag mismatch: same index, same counter, other tag
        look(32'h4100, 3'd4, "R4 tag mismatch");
        chk("R4 tag mismatch not taken", 32'(pred_taken), 32'd0);
        chk("R4 tag mismatch next_pc", next_pc, 32'h4110);

        // R8 lookup and update of the same entry in one cycle
        @(negedge clk);
        redirect = 1'b1;
        redir_pc = 32'h5020;
        @(negedge clk);
        redirect   = 1'b0;
        grp_width  = 3'd4;
        upd_en     = 1'b1;
        upd_pc     = 32'h5020;
        upd_slot   = 2'd1;
        upd_target = 32'h7770;
        upd_taken  = 1'b1;
        #1;
        chk("R8 same-cycle cur_pc", cur_pc, 32'h5020);
        chk("R8 same-cycle old next_pc", next_pc, 32'h5030);
        chk("R8 same-cycle old mask", 32'(slot_valid), 32'hF);
        chk("R8 same-cycle old taken", 32'(pred_taken), 32'd0);
        @(negedge clk);
        upd_en = 1'b0;
        #1;
        chk("R10 after update cur_pc", cur_pc, 32'h5030);
        look(32'h5020, 3'd4, "R8 after update");
        chk("R8 new taken", 32'(pred_taken), 32'd1);
        chk("R8 new next_pc", next_pc, 32'h7770);
        chk("R8 new mask", 32'(slot_valid), 32'h3);

        // R9 redirect while a taken branch is predicted
        @(negedge clk);
        redirect = 1'b1;
        redir_pc = 32'h5020;
        @(negedge clk);
        redir_pc = 32'h6000;
        #1;
        chk("R9 override cur_pc", cur_pc, 32'h5020);
        chk("R9 override next_pc", next_pc, 32'h6000);
        chk("R9 override mask", 32'(slot_valid), 32'd0);
        chk("R9 override taken", 32'(pred_taken), 32'd0);
        @(negedge clk);
        redirect = 1'b0;
        #1;
        chk("R9 override loaded", cur_pc, 32'h6000);

        // R10 free run through trained and untrained groups
        look(32'h4000, 3'd2, "R10 run start");
        for (int c = 0; c < 24; c++) begin
            prev_next = next_pc;
            @(negedge clk);
            grp_width = 3'(c % 5);
            #1;
            chk("R10 run cur_pc", cur_pc, prev_next);
            check_model("R10 run");
        end

        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule